// File: doc/BRIEF.md
# Rewindable Synchronous FIFO

This block is a single-clock FIFO for words of a parameterised width. Its read side can be rewound on request so that it reads its contents again, starting from physical location zero, while the write side carries on. A master reset sets two configuration options: the read-side flag style and the rewind latency. The first option selects either a standard read port, where data is registered after each read and the flag means "empty", or a fall-through port, where the head word sits on the output and the flag means "word ready". The second option selects either zero-latency or normal-latency rewind.

Two programmable thresholds drive an almost-empty output and an almost-full output. Their offsets are loaded one bit at a time through the write port. A rewind changes neither the offsets nor the configuration.

A small controller with three states handles rewind latency. In `ST_RUN` the flags are live and reads are accepted. A rewind request in normal-latency mode moves the controller to `ST_HOLD2`, from any state. The controller then always steps to `ST_HOLD1` and then back to `ST_RUN`. A rewind request in zero-latency mode moves the controller to `ST_RUN`, from any state.

Top module: `rewind_fifo`

## Requirements
- R1: `cfg_fwft` and `cfg_rt_timing` are sampled only on clock edges while `rst_n` is low. Changing them after reset has no effect.
- R2: A word is stored on a rising edge when `wen`=1, `sen`=0 and `full`=0. `full` is high when DEPTH words are held. A write attempted while full is dropped.
- R3: In standard mode (`cfg_fwft`=0), `rd_flag`=1 means empty. An accepted read puts the head word on `rdata` after the same edge. A read while `rd_flag`=1 is ignored, and `rdata` holds its value.
- R4: In fall-through mode (`cfg_fwft`=1), `rd_flag`=1 means the head word is already on `rdata`. A read with `ren`=1 shows the next word after the edge.
- R5: `rt`=1 on an edge sets the read position to location zero and leaves the write position alone. The held count then becomes the write position modulo DEPTH. If that value is zero and at least one word has been written since reset, the count becomes DEPTH. `full` follows this new count.
- R6: With `cfg_rt_timing`=0 (zero latency), the flags are valid on the cycle after `rt`. In fall-through mode, the word at location zero is on `rdata` in that cycle.
- R7: With `cfg_rt_timing`=1 (normal latency), the flags read "no data" after the `rt` edge and after the next edge. Reads are ignored during that time, and the flags come back live after the second edge following `rt`.
- R8: `sen`=1 together with `wen`=1 shifts `wdata[0]` into a 2*AW-bit offset register and writes no data. Bits enter at the LSB. After 2*AW shifts, the upper AW bits are the almost-full offset and the lower AW bits are the almost-empty offset, so the first bit shifted becomes the MSB of the almost-full offset.
- R9: `pae` = (count <= almost-empty offset). `paf` = (count >= DEPTH - almost-full offset). Both offsets reset to 2, and a rewind does not change them.
- R10: After reset the count is 0, `full`=0, `pae`=1 and `paf`=0. `rd_flag` is 1 in standard mode and 0 in fall-through mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous master reset, active low |
| cfg_fwft | input | 1 | Flag style, sampled in reset: 1 = fall-through |
| cfg_rt_timing | input | 1 | Rewind latency, sampled in reset: 0 = zero, 1 = normal |
| wen | input | 1 | Write enable |
| sen | input | 1 | Serial offset load enable (used with `wen`) |
| wdata | input | WIDTH | Write data; bit 0 is the serial offset bit |
| full | output | 1 | FIFO holds DEPTH words |
| ren | input | 1 | Read enable |
| rt | input | 1 | Rewind read side to location zero |
| rdata | output | WIDTH | Read data |
| rd_flag | output | 1 | Empty (standard) or word ready (fall-through) |
| pae | output | 1 | Almost empty |
| paf | output | 1 | Almost full |

## Verification
A read position that is not cleared by a rewind shows on the first read that follows: the wrong word appears on `rdata`, or the flag reports empty with the wrong number of words left. A rewind that moves the write side shows as a changed count, which `full`, `paf` or the flag report within the following edges. A latency controller stuck in the wrong state flips `rd_flag` one or two cycles early or late. Offsets that shift in the wrong order, or that a rewind corrupts, change `pae` as soon as the count crosses the intended threshold.

// File: rtl/rtf_pkg.sv
package rtf_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HOLD2 = 2'd1,
        ST_HOLD1 = 2'd2
    } rt_state_e;

    typedef struct packed {
        logic fwft;
        logic normal_lat;
    } rt_cfg_t;
endpackage

// File: rtl/rtf_ctrl.sv
module rtf_ctrl
    import rtf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rt,
    input  logic normal_lat,
    output logic live
);
    rt_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (rt) begin
            state_d = normal_lat ? ST_HOLD2 : ST_RUN;
        end else begin
            unique case (state_q)
                ST_RUN:   state_d = ST_RUN;
                ST_HOLD2: state_d = ST_HOLD1;
                ST_HOLD1: state_d = ST_RUN;
                default:  state_d = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        live = (state_q == ST_RUN);
    end

    // R7
    hold_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rt && normal_lat) |=> (!live ##1 !live));

    // R6
    zero_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rt && !normal_lat) |=> live);
endmodule

// File: rtl/rtf_mem.sv
module rtf_mem #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/rtf_offsets.sv
module rtf_offsets #(
    parameter int OW     = 4,
    parameter int AE_DEF = 2,
    parameter int AF_DEF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          bit_in,
    output logic [OW-1:0] ae_off,
    output logic [OW-1:0] af_off
);
    logic [2*OW-1:0] sreg;

    always_ff @(posedge clk) begin
        if (!rst_n)        sreg <= {OW'(AF_DEF), OW'(AE_DEF)};
        else if (shift_en) sreg <= {sreg[2*OW-2:0], bit_in};
    end

    assign af_off = sreg[2*OW-1:OW];
    assign ae_off = sreg[OW-1:0];

    // R8
    offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sreg));
endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
    import rtf_pkg::*;
#(
    parameter int WIDTH  = 18,
    parameter int DEPTH  = 16,
    parameter int AE_DEF = 2,
    parameter int AF_DEF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_fwft,
    input  logic             cfg_rt_timing,
    input  logic             wen,
    input  logic             sen,
    input  logic [WIDTH-1:0] wdata,
    output logic             full,
    input  logic             ren,
    input  logic             rt,
    output logic [WIDTH-1:0] rdata,
    output logic             rd_flag,
    output logic             pae,
    output logic             paf
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    rt_cfg_t          cfg_q;
    logic [PW-1:0]    wptr, rptr, cnt, rew_ptr;
    logic [WIDTH-1:0] mem_q, rd_q;
    logic [AW-1:0]    ae_off, af_off;
    logic             written, live, have_data, wr_acc, rd_acc;

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '{fwft: cfg_fwft, normal_lat: cfg_rt_timing};
    end

    rtf_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rt         (rt),
        .normal_lat (cfg_q.normal_lat),
        .live       (live)
    );

    rtf_offsets #(.OW(AW), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_offs (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (wen && sen),
        .bit_in   (wdata[0]),
        .ae_off   (ae_off),
        .af_off   (af_off)
    );

    rtf_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (wr_acc),
        .waddr (wptr[AW-1:0]),
        .wdata (wdata),
        .raddr (rptr[AW-1:0]),
        .rdata (mem_q)
    );

    assign cnt       = wptr - rptr;
    assign full      = (cnt == DEPTH_P);
    assign have_data = (cnt != '0);
    assign wr_acc    = wen && !sen && !full;
    assign rd_acc    = ren && live && have_data && !rt;
    assign rew_ptr   = {wptr[AW] ^ (written && (wptr[AW-1:0] == '0)), {AW{1'b0}}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            written <= 1'b0;
        end else if (wr_acc) begin
            wptr    <= wptr + 1'b1;
            written <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rptr <= '0;
        else if (rt)     rptr <= rew_ptr;
        else if (rd_acc) rptr <= rptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rd_q <= '0;
        else if (rd_acc) rd_q <= mem_q;
    end

    assign rd_flag = cfg_q.fwft ? (live && have_data) : !(live && have_data);
    assign rdata   = cfg_q.fwft ? mem_q : rd_q;
    assign pae     = (cnt <= {1'b0, ae_off});
    assign paf     = (cnt >= (DEPTH_P - {1'b0, af_off}));

    // R1
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(cfg_q));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wen && !sen) |=> $stable(wptr));

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= DEPTH_P);

    // R5
    rewind_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt |=> (rptr[AW-1:0] == '0));

    // R5
    rewind_keeps_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rt && !wen) |=> $stable(wptr));
endmodule

// File: tb/sim_rewind_fifo.sv
module sim_rewind_fifo;
    localparam int W = 18;

    typedef struct packed {
        logic [1:0]   op;
        logic [W-1:0] d;
        logic         ef;
        logic [W-1:0] rd;
    } vec_t;

    // op: 0 idle, 1 write, 2 read, 3 rewind
    localparam vec_t VEC [12] = '{
        '{2'd1, 18'h100, 1'b0, 18'h000},  // R2
        '{2'd1, 18'h101, 1'b0, 18'h000},  // R2
        '{2'd1, 18'h102, 1'b0, 18'h000},  // R2
        '{2'd2, 18'h000, 1'b0, 18'h100},  // R3
        '{2'd2, 18'h000, 1'b0, 18'h101},  // R3
        '{2'd3, 18'h000, 1'b1, 18'h101},  // R7 hold begins
        '{2'd2, 18'h000, 1'b1, 18'h101},  // R7 read ignored
        '{2'd0, 18'h000, 1'b0, 18'h101},  // R7 live again
        '{2'd2, 18'h000, 1'b0, 18'h100},  // R5 location zero
        '{2'd2, 18'h000, 1'b0, 18'h101},  // R5
        '{2'd2, 18'h000, 1'b1, 18'h102},  // R3 now empty
        '{2'd2, 18'h000, 1'b1, 18'h102}   // R3 read when empty
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_fwft = 1'b0, cfg_rt_timing = 1'b1;
    logic wen = 1'b0, sen = 1'b0, ren = 1'b0, rt = 1'b0;
    logic [W-1:0] wdata = '0, rdata;
    logic full, rd_flag, pae, paf;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rewind_fifo u0 (
        .clk(clk), .rst_n(rst_n), .cfg_fwft(cfg_fwft), .cfg_rt_timing(cfg_rt_timing),
        .wen(wen), .sen(sen), .wdata(wdata), .full(full), .ren(ren), .rt(rt),
        .rdata(rdata), .rd_flag(rd_flag), .pae(pae), .paf(paf)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(logic w, logic r, logic s, logic t, logic [W-1:0] d);
        @(negedge clk);
        wen = w; ren = r; sen = s; rt = t; wdata = d;
        @(posedge clk);
        #1;
        wen = 0; ren = 0; sen = 0; rt = 0; wdata = '0;
        #1;
    endtask

    task automatic do_reset(logic fw, logic tm);
        @(negedge clk);
        rst_n = 0; cfg_fwft = fw; cfg_rt_timing = tm;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // Standard mode, normal-latency rewind
        do_reset(1'b0, 1'b1);
        chk("R10 rd_flag", rd_flag, 1);
        chk("R10 full", full, 0);
        chk("R10 pae", pae, 1);
        chk("R10 paf", paf, 0);

        for (int i = 0; i < 12; i++) begin
            step(VEC[i].op == 2'd1, VEC[i].op == 2'd2, 1'b0, VEC[i].op == 2'd3, VEC[i].d);
            chk($sformatf("R3/R5/R7 vec%0d flag", i), rd_flag, VEC[i].ef);
            chk($sformatf("R3/R5/R7 vec%0d rdata", i), rdata, VEC[i].rd);
        end

        // R2 fill to DEPTH (write index 3..18)
        for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 18'h200 + 18'(i));
        chk("R2 full", full, 1);
        chk("R9 paf at full", paf, 1);
        step(1, 0, 0, 0, 18'h3FF);
        chk("R2 write while full", full, 1);
        // R5 rewind: write position 19 -> count 3
        step(0, 0, 0, 1, '0);
        chk("R5 full after rewind", full, 0);
        chk("R9 paf after rewind", paf, 0);
        chk("R7 flag held", rd_flag, 1);
        step(0, 0, 0, 0, '0);
        chk("R7 flag held 2", rd_flag, 1);
        step(0, 0, 0, 0, '0);
        chk("R7 flag live", rd_flag, 0);
        step(0, 1, 0, 0, '0);
        chk("R5 loc0 word", rdata, 18'h20D);
        step(0, 1, 0, 0, '0);
        chk("R5 loc1 word", rdata, 18'h20E);
        step(0, 1, 0, 0, '0);
        chk("R5 loc2 word", rdata, 18'h20F);
        chk("R5 count exhausted", rd_flag, 1);

        // Fall-through mode, zero-latency rewind; later config changes ignored
        do_reset(1'b1, 1'b0);
        cfg_fwft = 0; cfg_rt_timing = 1;
        chk("R10 fwft rd_flag", rd_flag, 0);
        // R8 load af=1, ae=5: bits 0001_0101, first bit lands in af MSB
        for (int i = 7; i >= 0; i--) step(1, 0, 1, 0, 18'(((8'h15) >> i) & 1));
        chk("R8 no data written", rd_flag, 0);
        step(1, 0, 0, 0, 18'h011);
        chk("R4 head ready", rd_flag, 1);
        chk("R4 head word", rdata, 18'h011);
        chk("R1 flag style kept", rd_flag, 1);
        step(1, 0, 0, 0, 18'h022);
        step(1, 0, 0, 0, 18'h033);
        chk("R8 R9 pae with new offset", pae, 1);
        step(0, 1, 0, 0, '0);
        chk("R4 next word", rdata, 18'h022);
        step(0, 1, 0, 0, '0);
        chk("R4 third word", rdata, 18'h033);
        step(0, 0, 0, 1, '0);
        chk("R6 ready right after rewind", rd_flag, 1);
        chk("R6 loc0 shown", rdata, 18'h011);
        chk("R9 offset kept by rewind", pae, 1);
        step(0, 1, 0, 0, '0);
        chk("R6 read resumes", rdata, 18'h022);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule